// File: doc/BRIEF.md
# PHY Register Write Sequencer

This block turns a single host request ("write this 16-bit value to this 8-bit register of the transmitter PHY") into the ordered series of byte-wide register loads that a small I2C-style master engine needs. It then launches the engine's write operation and waits for the engine to report an outcome. The host sees a one-cycle `start` strobe, a `busy` level, and three sticky result flags: `done`, `err` and `timeout`.

On the engine side every byte load is a request held until the engine acknowledges it. Once the write is launched, the block samples the engine's completion and error status at fixed poll intervals. The number of polls is bounded, so a silent engine cannot hang the host. The poll interval and the poll budget are parameters. Silicon sets them so that 100 polls of 10 ms give a one-second budget. A simulation can make them a few cycles.

Top module: `phy_wr_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy`, `done`, `err`, `timeout` and `eng_req` are all 0 after that edge.
- R2: A `start` sampled while idle raises `busy` at that edge and clears `done`, `err` and `timeout` at the same edge.
- R3: A transfer issues exactly six engine writes, with `eng_sel` codes in this order:
  - 0 carries the device address as `{1'b0, dev_addr}`.
  - 1 clears status with data 8'h03 (bit 0 done, bit 1 error).
  - 2 carries the register address.
  - 3 carries data bits 15:8.
  - 4 carries data bits 7:0.
  - 5 launches the write with data 8'h10.
- R4: `dev_addr`, `reg_addr` and `wr_data` are captured at the accepting edge, so later changes to them do not alter the writes of that transfer.
- R5: Each engine write holds `eng_req`, `eng_sel` and `eng_wdata` steady until the edge at which `eng_ack` is high. It completes at that edge.
- R6: The wait samples status every `POLL_CYCLES` cycles after the launch edge. If `eng_done` is set D cycles after the launch edge, `busy` falls and `done` rises `POLL_CYCLES*(D/POLL_CYCLES+1)` cycles after the launch edge.
- R7: An `eng_err` seen at a poll ends the wait with `err` set, with the same timing as R6.
- R8: When `eng_done` and `eng_err` are both seen at the same poll, only `err` is reported.
- R9: If no status flag is seen at any of the `POLL_LIMIT` polls, `busy` falls `POLL_CYCLES*POLL_LIMIT` cycles after the launch edge. In that case `timeout` is set, and `err` and `done` stay 0.
- R10: A `start` while `busy` is high is ignored. No extra engine write is issued, and the running transfer ends at its normal time.
- R11: In idle, at most one result flag is set, and it holds until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe from host |
| dev_addr | input | DEV_W | PHY device address on the serial bus |
| reg_addr | input | 8 | PHY register address |
| wr_data | input | 16 | Value to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed |
| err | output | 1 | Last transfer reported an engine error |
| timeout | output | 1 | Last transfer ran out of poll budget |
| eng_req | output | 1 | Engine register write request |
| eng_sel | output | 3 | Engine register select code |
| eng_wdata | output | 8 | Engine register write data |
| eng_ack | input | 1 | Engine accepts the current write |
| eng_done | input | 1 | Engine completion status flag |
| eng_err | input | 1 | Engine error status flag |

## Verification
The engine's completion flag and its error flag can both be seen at the same poll tick. When that happens the block has to pick one outcome. The bench provokes this case by having its engine responder raise both flags on the same edge a fixed delay after the launch write. It then judges the result by `err` set, `done` clear and the exact cycle at which `busy` falls. A host `start` arriving during the poll wait is also provoked. It is judged by the count and content of the logged engine writes and by an unchanged completion time.

// File: rtl/phy_wr_pkg.sv
// Package: shared constants and types for the PHY register write sequencer.
// Assumes a byte-wide engine register file with six write targets.
package phy_wr_pkg;
    localparam int BYTE_W    = 8;
    localparam int DATA_W    = 2 * BYTE_W;
    localparam int SEL_W     = 3;
    localparam int NUM_LOADS = 6;

    // Engine write targets; the step index equals the select code, so the
    // order of this list is the order of the load sequence.
    localparam logic [SEL_W-1:0] SEL_DEV = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CLR = 3'd1;
    localparam logic [SEL_W-1:0] SEL_REG = 3'd2;
    localparam logic [SEL_W-1:0] SEL_DHI = 3'd3;
    localparam logic [SEL_W-1:0] SEL_DLO = 3'd4;
    localparam logic [SEL_W-1:0] SEL_OP  = 3'd5;

    localparam logic [BYTE_W-1:0] CLR_FLAGS = 8'h03;
    localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/phy_wr_load_mux.sv
// Load mux: maps the current load step to the engine register select and
// the byte written there. Purely combinational; assumes captured request
// fields are stable for the whole load phase.
module phy_wr_load_mux
    import phy_wr_pkg::*;
#(
    parameter int DEV_W = 7
) (
    input  logic [SEL_W-1:0]  step,
    input  logic [DEV_W-1:0]  dev_q,
    input  logic [BYTE_W-1:0] reg_q,
    input  logic [DATA_W-1:0] data_q,
    output logic [SEL_W-1:0]  sel,
    output logic [BYTE_W-1:0] wdata
);
    localparam int PAD_W = BYTE_W - DEV_W;

    // Select the byte for the current step.
    always_comb begin
        sel = step;
        case (step)
            SEL_DEV: wdata = {{PAD_W{1'b0}}, dev_q};
            SEL_CLR: wdata = CLR_FLAGS;
            SEL_REG: wdata = reg_q;
            SEL_DHI: wdata = data_q[DATA_W-1:BYTE_W];
            SEL_DLO: wdata = data_q[BYTE_W-1:0];
            SEL_OP:  wdata = OP_WRITE;
            default: wdata = '0;
        endcase
    end
endmodule

// File: rtl/phy_wr_poll_timer.sv
// Poll timer: while run is high, produces a tick every POLL_CYCLES cycles
// and flags the tick that uses up the POLL_LIMIT budget. Counters return
// to zero whenever run is low, so each wait starts a fresh budget.
module phy_wr_poll_timer #(
    parameter int POLL_CYCLES = 1000,
    parameter int POLL_LIMIT  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick,
    output logic last
);
    localparam int CNT_W = $clog2(POLL_CYCLES + 1);
    localparam int NUM_W = $clog2(POLL_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(POLL_CYCLES - 1);
    localparam logic [NUM_W-1:0] NUM_END = NUM_W'(POLL_LIMIT - 1);

    logic [CNT_W-1:0] cyc_cnt;
    logic [NUM_W-1:0] poll_num;

    // Interval counter and poll counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cyc_cnt  <= '0;
            poll_num <= '0;
        end else if (cyc_cnt == CNT_END) begin
            cyc_cnt  <= '0;
            poll_num <= poll_num + 1'b1;
        end else begin
            cyc_cnt <= cyc_cnt + 1'b1;
        end
    end

    assign tick = run && (cyc_cnt == CNT_END);
    assign last = tick && (poll_num == NUM_END);
endmodule

// File: rtl/phy_wr_seq.sv
// PHY register write sequencer top. Accepts a host write request, loads
// the engine registers in a fixed order with a request/ack handshake,
// launches the write and polls completion/error status under a bounded
// budget. Assumes eng_done/eng_err are level flags cleared by the
// status-clear write and synchronous to clk.
module phy_wr_seq
    import phy_wr_pkg::*;
#(
    parameter int DEV_W       = 7,
    parameter int POLL_CYCLES = 1000,
    parameter int POLL_LIMIT  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DEV_W-1:0]  dev_addr,
    input  logic [7:0]        reg_addr,
    input  logic [15:0]       wr_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              timeout,
    output logic              eng_req,
    output logic [2:0]        eng_sel,
    output logic [7:0]        eng_wdata,
    input  logic              eng_ack,
    input  logic              eng_done,
    input  logic              eng_err
);
    localparam logic [SEL_W-1:0] LAST_STEP = SEL_W'(NUM_LOADS - 1);

    seq_state_e        state;
    logic [SEL_W-1:0]  step;
    logic [DEV_W-1:0]  dev_q;
    logic [BYTE_W-1:0] reg_q;
    logic [DATA_W-1:0] data_q;
    logic              poll_tick;
    logic              poll_last;

    phy_wr_load_mux #(.DEV_W(DEV_W)) u_mux (
        .step   (step),
        .dev_q  (dev_q),
        .reg_q  (reg_q),
        .data_q (data_q),
        .sel    (eng_sel),
        .wdata  (eng_wdata)
    );

    phy_wr_poll_timer #(
        .POLL_CYCLES (POLL_CYCLES),
        .POLL_LIMIT  (POLL_LIMIT)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_WAIT),
        .tick  (poll_tick),
        .last  (poll_last)
    );

    // Sequencer: capture, load steps, poll wait and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            step    <= '0;
            dev_q   <= '0;
            reg_q   <= '0;
            data_q  <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            timeout <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        dev_q   <= dev_addr;
                        reg_q   <= reg_addr;
                        data_q  <= wr_data;
                        step    <= '0;
                        done    <= 1'b0;
                        err     <= 1'b0;
                        timeout <= 1'b0;
                        state   <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (eng_ack) begin
                        if (step == LAST_STEP) begin
                            state <= ST_WAIT;
                        end else begin
                            step <= step + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (poll_tick) begin
                        if (eng_err) begin
                            err   <= 1'b1;
                            state <= ST_IDLE;
                        end else if (eng_done) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else if (poll_last) begin
                            timeout <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign eng_req = (state == ST_LOAD);
endmodule

// File: rtl/phy_wr_seq_chk.sv
// Checker: temporal properties of the sequencer ports, bound to the top.
module phy_wr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       timeout,
    input logic       eng_req,
    input logic [2:0] eng_sel,
    input logic [7:0] eng_wdata,
    input logic       eng_ack
);
    // Accepted start raises busy and clears results.
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done && !err && !timeout));

    // Pending write is held stable until acknowledged.
    assert_hold_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> (eng_req && $stable(eng_sel) && $stable(eng_wdata)));

    // Engine requests only occur inside a transfer.
    assert_req_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> busy);

    // Never more than one result flag.
    assert_one_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({done, err, timeout}) <= 1);

    // Every finished transfer reports exactly one outcome.
    assert_end_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($countones({done, err, timeout}) == 1));

    // Results hold in idle without a new start.
    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(done) && $stable(err) && $stable(timeout)));

    // Error outranks completion.
    assert_err_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !done);
endmodule

bind phy_wr_seq phy_wr_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .timeout   (timeout),
    .eng_req   (eng_req),
    .eng_sel   (eng_sel),
    .eng_wdata (eng_wdata),
    .eng_ack   (eng_ack)
);

// File: tb/tb_phy_wr_seq.sv
// Directed bench with an engine responder that acknowledges and logs writes.
module tb_phy_wr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PC = 4;
    localparam int PL = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] dev_addr = '0;
    logic [7:0] reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic       busy, done, err, timeout, eng_req;
    logic [2:0] eng_sel;
    logic [7:0] eng_wdata;
    logic       eng_ack = 1'b0;
    logic       eng_done = 1'b0;
    logic       eng_err = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int lg_n = 0;
    int op_edge = 0;
    logic [2:0] lg_sel [0:63];
    logic [7:0] lg_dat [0:63];
    int ack_wait = 0;
    int wcnt = 0;
    int dcnt = 0;
    int resp_dly = 0;
    bit resp_done = 0;
    bit resp_err = 0;
    bit finished = 0;

    phy_wr_seq #(.DEV_W(7), .POLL_CYCLES(PC), .POLL_LIMIT(PL)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr),
        .reg_addr(reg_addr), .wr_data(wr_data), .busy(busy), .done(done),
        .err(err), .timeout(timeout), .eng_req(eng_req), .eng_sel(eng_sel),
        .eng_wdata(eng_wdata), .eng_ack(eng_ack), .eng_done(eng_done),
        .eng_err(eng_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Engine responder: ack after ack_wait cycles, log writes, model status flags.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            eng_ack <= 1'b0; eng_done <= 1'b0; eng_err <= 1'b0;
            wcnt <= 0; dcnt <= 0;
        end else begin
            if (eng_ack) eng_ack <= 1'b0;
            else if (eng_req) begin
                if (wcnt >= ack_wait) begin eng_ack <= 1'b1; wcnt <= 0; end
                else wcnt <= wcnt + 1;
            end
            if (eng_req && eng_ack) begin
                lg_sel[lg_n % 64] <= eng_sel;
                lg_dat[lg_n % 64] <= eng_wdata;
                lg_n <= lg_n + 1;
                if (eng_sel == 3'd1) begin eng_done <= 1'b0; eng_err <= 1'b0; end
                if (eng_sel == 3'd5) begin op_edge <= cyc + 1; dcnt <= resp_dly; end
            end else if (dcnt > 0) begin
                dcnt <= dcnt - 1;
                if (dcnt == 1) begin eng_done <= resp_done; eng_err <= resp_err; end
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({busy, done, err, timeout, eng_req} == 5'b0, "R1 outputs in reset",
            int'({busy, done, err, timeout, eng_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, eng_req} == 2'b0, "R1 idle after reset", int'({busy, eng_req}), 0);
    endtask

    // One transfer; checks write log, outcome, timing and result holding.
    task automatic run_txn(input string rq, input logic [6:0] dv, input logic [7:0] ra,
                           input logic [15:0] wd, input bit rdone, input bit rerr,
                           input int dly, input int ackw, input bit disturb, input bit poke);
        int base, fall, g, exp_t;
        bit poked;
        logic [7:0] expd [0:5];
        resp_done = rdone; resp_err = rerr; resp_dly = dly; ack_wait = ackw;
        base = lg_n; g = 0; poked = 0;
        expd[0] = {1'b0, dv}; expd[1] = 8'h03; expd[2] = ra;
        expd[3] = wd[15:8]; expd[4] = wd[7:0]; expd[5] = 8'h10;
        @(negedge clk);
        dev_addr = dv; reg_addr = ra; wr_data = wd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done && !err && !timeout, "R2 accept", int'({busy, done, err, timeout}), 8);
        if (disturb) begin dev_addr = ~dv; reg_addr = ~ra; wr_data = ~wd; end
        while (busy && g < 5000) begin
            if (poke && !poked && lg_n == base + 6) begin
                start = 1'b1; reg_addr = 8'h5a; poked = 1;
            end else start = 1'b0;
            @(negedge clk);
            g++;
        end
        start = 1'b0;
        fall = cyc;
        chk(lg_n - base == 6, poke ? "R10 write count" : "R3 write count", lg_n - base, 6);
        for (int k = 0; k < 6; k++) begin
            chk(lg_sel[(base + k) % 64] == 3'(k), "R3 select order",
                int'(lg_sel[(base + k) % 64]), k);
            chk(lg_dat[(base + k) % 64] == expd[k], disturb ? "R4 captured data" : "R3 write data",
                int'(lg_dat[(base + k) % 64]), int'(expd[k]));
        end
        exp_t = (rdone || rerr) ? PC * (dly / PC + 1) : PC * PL;
        chk(fall - op_edge == exp_t, rq, fall - op_edge, exp_t);
        chk(err == rerr, rq, int'(err), int'(rerr));
        chk(done == (rdone && !rerr), rq, int'(done), int'(rdone && !rerr));
        chk(timeout == (!rdone && !rerr), "R9 timeout flag", int'(timeout), int'(!rdone && !rerr));
        repeat (3) @(negedge clk);
        chk(!busy && !eng_req && done == (rdone && !rerr) && err == rerr,
            "R11 result held", int'({busy, eng_req, done, err}), int'({2'b0, rdone && !rerr, rerr}));
    endtask

    initial begin
        t_reset();
        run_txn("R6 done timing", 7'h69, 8'h13, 16'hA5C3, 1, 0, 6, 0, 0, 0);
        run_txn("R6 done at boundary", 7'h11, 8'h06, 16'h0F1E, 1, 0, 8, 2, 1, 0);
        run_txn("R7 error", 7'h22, 8'h10, 16'h1234, 0, 1, 3, 1, 0, 0);
        run_txn("R8 done and error together", 7'h33, 8'h20, 16'hFFFF, 1, 1, 5, 0, 0, 0);
        run_txn("R9 timeout timing", 7'h44, 8'h30, 16'h8001, 0, 0, 0, 0, 0, 0);
        run_txn("R10 start ignored while busy", 7'h55, 8'h0E, 16'h6dc0, 1, 0, 10, 0, 0, 1);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule